// File: doc/BRIEF.md
# Serial-Loaded Latched Switch Controller

This block is the logic front end of an eight-way switch array. Switch settings arrive one bit at a time on a serial input and are clocked into a chain of storage stages on the rising edge of a shift clock. A bank of level-sensitive latches sits between the chain and the switch-enable outputs. While the active-high `freeze` input is low, the latches are transparent and the outputs track the chain. While `freeze` is high, the outputs keep the state they had when `freeze` rose, even if new data keeps arriving.

The last stage of the chain drives a serial output. Several copies can therefore be strung together on a shared clock, with each serial output feeding the next copy's serial input. An active-high `wipe` input overrides every other input. It empties the chain and the latches asynchronously, so every switch turns off in the same time step that `wipe` rises. The analog switches, their level shifting and their discharge resistors are outside this block. Each switch appears here only as one enable bit.

Top module: `serial_switch_ctrl`

## Requirements
- R1: On every rising edge of `shift_clk` while `wipe` is low, `ser_in` is stored in stage 0 and each stage k takes the old value of stage k-1, up to the last stage.
- R2: Enable bit k of `sw_en` drives switch k: 1 means ON, 0 means OFF. Bit k comes from stage k, so a byte sent most-significant bit first with `freeze` low appears on `sw_en` as that same byte (bit 7 = first bit sent) after eight clocks.
- R3: While `freeze` is low and `wipe` is low, `sw_en` equals the chain contents, and it follows each shift and the falling edge of `freeze` with no clock delay.
- R4: While `freeze` is high, `sw_en` does not change, however many bits are clocked into the chain.
- R5: The value held while `freeze` is high is the chain contents at the moment `freeze` rose.
- R6: While `wipe` is high, every stage and every latch reads 0, `sw_en` is 0 and `ser_out` is 0 in the same time step, whatever `shift_clk`, `ser_in` and `freeze` do. The chain is still empty when `wipe` falls.
- R7: `ser_out` always equals the last stage of the chain, independent of `freeze`.
- R8: Two instances chained through `ser_out` to `ser_in` act as one 16-stage chain. After sixteen clocks, the first bit sent sits in the last stage of the second instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock; data moves on its rising edge |
| wipe | input | 1 | Asynchronous clear, active high; empties chain and latches |
| freeze | input | 1 | High: latches hold; low: latches transparent |
| ser_in | input | 1 | Serial data into stage 0 |
| sw_en | output | STAGES | Switch enables, 1 = switch ON |
| ser_out | output | 1 | Last chain stage, for chaining to the next instance |

## Verification
The clocked properties rest on two assumptions. The first is that `freeze` changes no more than once between two clock edges. The second is that `wipe` starts high at time zero, so that no property is evaluated on uncleared storage. The stimulus honors both: it moves `ser_in`, `freeze` and `wipe` together, one nanosecond after a rising edge, and holds them for the rest of the cycle. It also raises `wipe` before the first edge. Outputs are compared at the falling edge, when both the clocked shift and any asynchronous latch or clear effect of the new inputs have settled.

// File: rtl/serial_switch_pkg.sv
package serial_switch_pkg;

    localparam int unsigned DEF_STAGES = 8;

    typedef enum logic {
        LATCH_OPEN = 1'b0,
        LATCH_HOLD = 1'b1
    } latch_mode_e;

    function automatic latch_mode_e mode_of(input logic freeze_lvl);
        return freeze_lvl ? LATCH_HOLD : LATCH_OPEN;
    endfunction

endpackage

// File: rtl/serial_switch_chain.sv
module serial_switch_chain #(
    parameter int unsigned STAGES = serial_switch_pkg::DEF_STAGES
) (
    input  logic              shift_clk,
    input  logic              wipe,
    input  logic              ser_in,
    output logic [STAGES-1:0] stage_q
);

    localparam int unsigned LAST = STAGES - 1;

    always_ff @(posedge shift_clk or posedge wipe) begin
        if (wipe) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[LAST-1:0], ser_in};
        end
    end

endmodule

// File: rtl/serial_switch_latches.sv
module serial_switch_latches #(
    parameter int unsigned STAGES = serial_switch_pkg::DEF_STAGES
) (
    input  logic              wipe,
    input  logic              freeze,
    input  logic [STAGES-1:0] latch_d,
    output logic [STAGES-1:0] latch_q
);

    import serial_switch_pkg::*;

    latch_mode_e mode;

    assign mode = mode_of(freeze);

    always_latch begin
        if (wipe) begin
            latch_q = '0;
        end else if (mode == LATCH_OPEN) begin
            latch_q = latch_d;
        end
    end

endmodule

// File: rtl/serial_switch_ctrl.sv
module serial_switch_ctrl #(
    parameter int unsigned STAGES = serial_switch_pkg::DEF_STAGES
) (
    input  logic              shift_clk,
    input  logic              wipe,
    input  logic              freeze,
    input  logic              ser_in,
    output logic [STAGES-1:0] sw_en,
    output logic              ser_out
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] stage_q;

    serial_switch_chain #(.STAGES(STAGES)) u_chain (
        .shift_clk (shift_clk),
        .wipe      (wipe),
        .ser_in    (ser_in),
        .stage_q   (stage_q)
    );

    serial_switch_latches #(.STAGES(STAGES)) u_latches (
        .wipe    (wipe),
        .freeze  (freeze),
        .latch_d (stage_q),
        .latch_q (sw_en)
    );

    assign ser_out = stage_q[LAST];

endmodule

// File: rtl/serial_switch_ctrl_chk.sv
module serial_switch_ctrl_chk #(
    parameter int unsigned STAGES = serial_switch_pkg::DEF_STAGES
) (
    input logic              shift_clk,
    input logic              wipe,
    input logic              freeze,
    input logic [STAGES-1:0] stage_q,
    input logic [STAGES-1:0] sw_en,
    input logic              ser_out
);

    localparam int unsigned LAST = STAGES - 1;

    // R1: each stage takes its lower neighbour's previous value
    assert_shift_R1: assert property (@(posedge shift_clk) disable iff (wipe)
        1'b1 |=> stage_q[LAST:1] == $past(stage_q[LAST-1:0]));

    // R7: serial output carries the old second-to-last stage after a shift
    assert_serout_R7: assert property (@(posedge shift_clk) disable iff (wipe)
        1'b1 |=> ser_out == $past(stage_q[LAST-1]));

    // R3: transparent latches mirror the chain
    assert_open_R3: assert property (@(posedge shift_clk) disable iff (wipe)
        !freeze |-> sw_en == stage_q);

    // R4: held enables do not move
    assert_hold_R4: assert property (@(posedge shift_clk) disable iff (wipe)
        (freeze && $past(freeze)) |-> $stable(sw_en));

    // R6: clear empties everything visible
    assert_clear_R6: assert property (@(posedge shift_clk)
        wipe |-> (sw_en == '0 && ser_out == 1'b0 && stage_q == '0));

endmodule

bind serial_switch_ctrl serial_switch_ctrl_chk #(.STAGES(STAGES)) u_chk (
    .shift_clk (shift_clk),
    .wipe      (wipe),
    .freeze    (freeze),
    .stage_q   (stage_q),
    .sw_en     (sw_en),
    .ser_out   (ser_out)
);

// File: tb/serial_switch_ctrl_test.sv
module serial_switch_ctrl_test;

    typedef struct {
        logic [7:0] sw_a;
        logic       so_a;
        logic [7:0] sw_b;
        logic       so_b;
        string      tag;
    } exp_t;

    logic       shift_clk = 1'b0;
    logic       wipe      = 1'b1;
    logic       freeze    = 1'b0;
    logic       ser_in    = 1'b0;
    logic [7:0] sw_a, sw_b;
    logic       so_a, so_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    exp_t sb[$];

    logic [7:0] m_sr_a = '0, m_sr_b = '0, m_lt_a = '0, m_lt_b = '0;

    always #2 shift_clk = ~shift_clk;

    serial_switch_ctrl uut (
        .shift_clk (shift_clk), .wipe (wipe), .freeze (freeze),
        .ser_in (ser_in), .sw_en (sw_a), .ser_out (so_a)
    );

    serial_switch_ctrl uut_next (
        .shift_clk (shift_clk), .wipe (wipe), .freeze (freeze),
        .ser_in (so_a), .sw_en (sw_b), .ser_out (so_b)
    );

    // monitor: compares the scoreboard against the ports
    always @(negedge shift_clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (sw_a !== e.sw_a || so_a !== e.so_a || sw_b !== e.sw_b || so_b !== e.so_b) begin
                errors++;
                $display("FAIL %s: got sw=%h/%h so=%b/%b expected sw=%h/%h so=%b/%b",
                         e.tag, sw_a, sw_b, so_a, so_b, e.sw_a, e.sw_b, e.so_a, e.so_b);
            end
        end
    end

    // driver: called at posedge+1, returns at the next posedge+1
    task automatic step(input logic b, input logic frz, input logic wp, input string tag);
        exp_t e;
        ser_in = b; freeze = frz; wipe = wp;
        if (wp) begin
            m_sr_a = '0; m_sr_b = '0; m_lt_a = '0; m_lt_b = '0;
        end else if (!frz) begin
            m_lt_a = m_sr_a; m_lt_b = m_sr_b;
        end
        e.sw_a = m_lt_a; e.so_a = m_sr_a[7];
        e.sw_b = m_lt_b; e.so_b = m_sr_b[7];
        e.tag  = tag;
        sb.push_back(e);
        @(posedge shift_clk);
        if (!wp) begin
            m_sr_b = {m_sr_b[6:0], m_sr_a[7]};
            m_sr_a = {m_sr_a[6:0], b};
            if (!frz) begin
                m_lt_a = m_sr_a; m_lt_b = m_sr_b;
            end
        end
        #1;
    endtask

    task automatic direct(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    initial begin
        @(posedge shift_clk); #1;
        step(1'b1, 1'b0, 1'b1, "R6 reset");
        step(1'b1, 1'b1, 1'b1, "R6 reset clocks ignored");
        direct(sw_a, 8'h00, "R6 reset enables");

        // R1 R3 R2: load A5 MSB first with latches open
        for (int i = 7; i >= 0; i--) step(8'hA5 >> i, 1'b0, 1'b0, "R1 R3 load");
        direct(sw_a, 8'hA5, "R2 byte mapping");
        direct({7'd0, so_a}, 8'd1, "R7 last stage out");

        // R5 R4: freeze, then shift 3C behind held outputs
        step(1'b0, 1'b1, 1'b0, "R5 capture");
        for (int i = 7; i >= 0; i--) step(8'h3C >> i, 1'b1, 1'b0, "R4 hold");
        direct(sw_a, 8'hA5, "R4 held value");
        direct({7'd0, so_a}, 8'd0, "R7 out while held");

        // R3: reopen, outputs jump to chain contents
        step(1'b0, 1'b0, 1'b0, "R3 reopen");

        // R6: clear while held and clocking
        step(1'b1, 1'b1, 1'b1, "R6 clear held");
        step(1'b1, 1'b0, 1'b1, "R6 clear open");
        step(1'b0, 1'b0, 1'b0, "R6 empty after clear");
        direct(sw_a, 8'h00, "R6 chain emptied");

        // R8: sixteen bits across two instances, MSB first
        for (int i = 15; i >= 0; i--) step(16'hC35A >> i, 1'b0, 1'b0, "R8 chain");
        direct(sw_b, 8'hC3, "R8 far instance");
        direct(sw_a, 8'h5A, "R8 near instance");
        direct({7'd0, so_b}, 8'd1, "R8 first bit at far end");

        // R6: immediate clear with latches open
        step(1'b1, 1'b0, 1'b1, "R6 immediate");
        step(1'b0, 1'b0, 1'b0, "R6 release");
        @(negedge shift_clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge shift_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule